// File: doc/BRIEF.md
# Indirect Addressing Pointer Unit

This block sits in the data path of an 8-bit controller with a 12-bit data address space. It keeps three pointer channels. Each channel is a 12-bit pointer written and read as a low byte plus a 4-bit high byte. Each channel also owns five virtual registers in the register file. An access to one of them is not served at that address. It is redirected to the address held in the pointer, and on the way the unit can step the pointer up or down, step it before use, or add the signed accumulator to it. Every other register-file address passes straight through to the data memory.

Instructions that read a register and then write it back are presented as a read strobe, then a write strobe, then an instruction-end strobe. Both strobes use the same redirected address. The post-step of the pointer is held as a pending signed delta and is committed only when the instruction ends. The unit refuses any redirected access whose target is itself one of the virtual registers. In that case it raises a flag, suppresses the memory strobes and returns zero.

Top module: `idx_ptr_unit`

## Requirements
- R1: After reset every pointer is zero and nothing is pending. With no strobe active, `mem_rd`, `mem_wr` and `forbid` are low and `ptr_rdata` is zero.
- R2: Channel c (c = 0, 1, 2) has base B = 0xFEB - 8*c. B+0 is the plain view, B+1 post-increment, B+2 post-decrement, B+3 pre-increment and B+4 the pointer-plus-accumulator view. B-2 is the low pointer byte and B-1 the high pointer byte. The high byte keeps only bits [3:0], and its upper four bits read as zero.
- R3: A read of a pointer byte returns the stored byte on `ptr_rdata` in the same cycle, and a write stores `wr_data` at the clock edge. Neither raises `mem_rd` or `mem_wr`.
- R4: Any address that is neither a view nor a pointer byte appears unchanged on `eff_addr`, with `mem_rd` = `rd_stb` and `mem_wr` = `wr_stb`.
- R5: The plain view drives the pointer onto `eff_addr` and leaves the pointer unchanged.
- R6: The post-increment and post-decrement views drive the current pointer, then add +1 or -1 (modulo 4096) at the edge on which `insn_end` is high.
- R7: The pre-increment view drives pointer+1 (modulo 4096) on its first strobe of an instruction and stores that value. Later strobes of the same instruction use the same address.
- R8: The accumulator view drives pointer + sign-extended `acc` (modulo 4096) and never changes the pointer.
- R9: In a read-then-write instruction on a post view, both strobes drive the old pointer. The pointer stays unchanged until `insn_end`.
- R10: When a post-view strobe and `insn_end` fall in the same cycle, the access uses the old pointer and the step is applied at that edge.
- R11: An address is a virtual register when ((a & 0xFC7) == 0xFC3 or (a & 0xFC4) == 0xFC4) and a[5:3] lies in 3..5. If the redirected target is one, `forbid` is high in that strobe cycle only. In that cycle `mem_rd`, `mem_wr` and `ptr_rdata` stay low and the pointer is not changed. `eff_addr` still shows the refused target.
- R12: A write to a pointer byte cancels that channel's pending step. The written value is the one the next access uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 12 | Register-file address of the current access |
| wr_data | input | 8 | Write data for pointer byte writes |
| rd_stb | input | 1 | Read phase of an access |
| wr_stb | input | 1 | Write phase of an access |
| insn_end | input | 1 | Last cycle of the instruction; pending steps commit |
| acc | input | 8 | Accumulator, signed offset for the accumulator view |
| eff_addr | output | 12 | Address presented to data memory |
| mem_rd | output | 1 | Data-memory read enable |
| mem_wr | output | 1 | Data-memory write enable |
| ptr_rdata | output | 8 | Pointer byte read data, zero otherwise |
| forbid | output | 1 | Refused access to a virtual register through a view |

## Verification
Two pairs of events can land in the same cycle. The first is a post-view strobe together with the instruction-end strobe. The bench drives both in one vector and then reads the pointer back to show that exactly one step was applied. The second is a pointer byte write that arrives while a post-increment step is still pending. The bench starts a post-increment read, writes the low byte before `insn_end`, closes the instruction, and expects the written value with no added step. It also checks a refused access that is followed at once by a legal one, to show that `forbid` does not linger.

// File: rtl/idx_ptr_pkg.sv
package idx_ptr_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 8;
  localparam int HI_W   = ADDR_W - DATA_W;

  typedef enum logic [2:0] {
    V_PLAIN   = 3'd0,
    V_POSTINC = 3'd1,
    V_POSTDEC = 3'd2,
    V_PREINC  = 3'd3,
    V_PLUSACC = 3'd4
  } view_e;

  // mask rule for "this address is a virtual indirect register"
  function automatic logic is_indirect_reg(input logic [ADDR_W-1:0] a);
    logic [2:0] mid;
    mid = a[5:3];
    return (((a & 12'hFC7) == 12'hFC3) || ((a & 12'hFC4) == 12'hFC4))
           && (mid >= 3'd3) && (mid <= 3'd5);
  endfunction

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] p,
                                                  input logic signed [1:0] d);
    return p + {{(ADDR_W-2){d[1]}}, d};
  endfunction

  function automatic logic [ADDR_W-1:0] offset_addr(input logic [ADDR_W-1:0] p,
                                                    input logic [DATA_W-1:0] off);
    return p + {{(ADDR_W-DATA_W){off[DATA_W-1]}}, off};
  endfunction
endpackage

// File: rtl/idx_ptr_decode.sv
module idx_ptr_decode
  import idx_ptr_pkg::*;
#(
  parameter int NCH     = 3,
  parameter int TOP_MID = 5,
  localparam int CW     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              view_hit,
  output logic              lo_hit,
  output logic              hi_hit,
  output logic [CW-1:0]     chan,
  output view_e             view
);
  logic [2:0] mid;
  logic [2:0] low;
  logic       page;
  logic       in_ch;

  always_comb begin
    mid      = addr[5:3];
    low      = addr[2:0];
    page     = &addr[ADDR_W-1:6];
    in_ch    = page && (int'(mid) <= TOP_MID) && (int'(mid) > TOP_MID - NCH);
    chan     = CW'(TOP_MID - int'(mid));
    view_hit = in_ch && (low >= 3'd3);
    lo_hit   = in_ch && (low == 3'd1);
    hi_hit   = in_ch && (low == 3'd2);
    view     = view_hit ? view_e'(low - 3'd3) : V_PLAIN;
  end
endmodule

// File: rtl/idx_ptr_chan.sv
module idx_ptr_chan
  import idx_ptr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  view_e             view,
  input  logic [DATA_W-1:0] acc,
  input  logic              go,
  input  logic              insn_end,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] eff
);
  logic [ADDR_W-1:0] ptr_q, base_n;
  logic              busy_q, busy_n;
  logic signed [1:0] dlt_q, dlt_n;
  logic              first_evt, cancel_evt, apply_evt;

  assign ptr        = ptr_q;
  assign first_evt  = go && !busy_q;
  assign cancel_evt = lo_we || hi_we;
  assign apply_evt  = insn_end && !cancel_evt && (dlt_n != 2'sd0);

  always_comb begin
    unique case (view)
      V_PREINC:  eff = busy_q ? ptr_q : step_addr(ptr_q, 2'sd1);
      V_PLUSACC: eff = offset_addr(ptr_q, acc);
      default:   eff = ptr_q;
    endcase
  end

  always_comb begin
    base_n = ptr_q;
    dlt_n  = dlt_q;
    busy_n = busy_q;
    if (first_evt) begin
      unique case (view)
        V_POSTINC: begin dlt_n = 2'sd1;  busy_n = 1'b1; end
        V_POSTDEC: begin dlt_n = -2'sd1; busy_n = 1'b1; end
        V_PREINC:  begin base_n = step_addr(ptr_q, 2'sd1); dlt_n = 2'sd0; busy_n = 1'b1; end
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      busy_q <= 1'b0;
      dlt_q  <= 2'sd0;
    end else if (cancel_evt) begin
      ptr_q  <= lo_we ? {ptr_q[ADDR_W-1:DATA_W], wdata}
                      : {wdata[HI_W-1:0], ptr_q[DATA_W-1:0]};
      busy_q <= 1'b0;
      dlt_q  <= 2'sd0;
    end else if (insn_end) begin
      ptr_q  <= apply_evt ? step_addr(base_n, dlt_n) : base_n;
      busy_q <= 1'b0;
      dlt_q  <= 2'sd0;
    end else begin
      ptr_q  <= base_n;
      busy_q <= busy_n;
      dlt_q  <= dlt_n;
    end
  end

  // R9: while a step is pending and the instruction is open, the pointer holds
  assert_read_phase_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !insn_end && !cancel_evt |=> $stable(ptr_q));

  // R8: the accumulator view never moves the pointer
  assert_plusacc_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    go && (view == V_PLUSACC) && !busy_q && !insn_end && !cancel_evt |=> $stable(ptr_q));

  // R6: a pending +1 commits at instruction end, wrapping at 4096
  assert_post_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    insn_end && busy_q && !cancel_evt && (dlt_q == 2'sd1)
    |=> ptr_q == $past(ptr_q) + 12'd1);

  // R12: a byte write leaves nothing pending
  assert_write_cancels_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_evt |=> !busy_q && (dlt_q == 2'sd0));
endmodule

// File: rtl/idx_ptr_unit.sv
module idx_ptr_unit
  import idx_ptr_pkg::*;
#(
  parameter int NCH     = 3,
  parameter int TOP_MID = 5,
  localparam int CW     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic              insn_end,
  input  logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] ptr_rdata,
  output logic              forbid
);
  logic          view_hit, lo_hit, hi_hit;
  logic [CW-1:0] chan;
  view_e         view;
  logic          strobe, tgt_bad, go_ok, direct;
  logic [ADDR_W-1:0] sel_eff, sel_ptr;
  logic [ADDR_W-1:0] eff_arr [NCH];
  logic [ADDR_W-1:0] ptr_arr [NCH];

  idx_ptr_decode #(.NCH(NCH), .TOP_MID(TOP_MID)) u_dec (
    .addr(reg_addr), .view_hit(view_hit), .lo_hit(lo_hit), .hi_hit(hi_hit),
    .chan(chan), .view(view)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel_c;
    assign sel_c = (chan == CW'(c));
    idx_ptr_chan u_chan (
      .clk(clk), .rst_n(rst_n), .view(view), .acc(acc),
      .go(go_ok && sel_c), .insn_end(insn_end),
      .lo_we(wr_stb && lo_hit && sel_c), .hi_we(wr_stb && hi_hit && sel_c),
      .wdata(wr_data), .ptr(ptr_arr[c]), .eff(eff_arr[c])
    );
  end

  always_comb begin
    sel_eff = '0;
    sel_ptr = '0;
    for (int c = 0; c < NCH; c++) begin
      if (chan == CW'(c)) begin
        sel_eff = eff_arr[c];
        sel_ptr = ptr_arr[c];
      end
    end
  end

  assign strobe   = rd_stb || wr_stb;
  assign tgt_bad  = is_indirect_reg(sel_eff);
  assign forbid   = view_hit && strobe && tgt_bad;
  assign go_ok    = view_hit && strobe && !tgt_bad;
  assign direct   = !view_hit && !lo_hit && !hi_hit;
  assign eff_addr = view_hit ? sel_eff : reg_addr;
  assign mem_rd   = rd_stb && ((view_hit && !tgt_bad) || direct);
  assign mem_wr   = wr_stb && ((view_hit && !tgt_bad) || direct);

  always_comb begin
    if (rd_stb && lo_hit)      ptr_rdata = sel_ptr[DATA_W-1:0];
    else if (rd_stb && hi_hit) ptr_rdata = {{(DATA_W-HI_W){1'b0}}, sel_ptr[ADDR_W-1:DATA_W]};
    else                       ptr_rdata = '0;
  end

  // R11: the positional decode and the mask rule agree on every address
  assert_decode_agrees_R11: assert property (@(posedge clk) disable iff (!rst_n)
    view_hit == is_indirect_reg(reg_addr));

  // R11: a refused access reaches neither memory nor the read data
  assert_forbid_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    forbid |-> !mem_rd && !mem_wr && (ptr_rdata == '0));

  // R11: the flag only ever accompanies a strobe
  assert_forbid_strobed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    forbid |-> strobe);

  // R3: pointer byte accesses stay off the memory port
  assert_byte_no_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_hit || hi_hit) |-> !mem_rd && !mem_wr);
endmodule

// File: tb/idx_ptr_unit_tb.sv
`timescale 1ns/1ps
module idx_ptr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [7:0]  wr_data = '0, acc = '0;
  logic        rd_stb = 1'b0, wr_stb = 1'b0, insn_end = 1'b0;
  logic [11:0] eff_addr;
  logic        mem_rd, mem_wr, forbid;
  logic [7:0]  ptr_rdata;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  idx_ptr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_data(wr_data),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .insn_end(insn_end), .acc(acc),
    .eff_addr(eff_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .ptr_rdata(ptr_rdata), .forbid(forbid)
  );

  typedef struct packed {
    logic [11:0] addr; logic [7:0] wd; logic rd; logic wr; logic en; logic [7:0] ac;
    logic [11:0] e_eff; logic e_mr; logic e_mw; logic [7:0] e_rd; logic e_fb; logic [3:0] req;
  } vec_t;

  function automatic vec_t mkv(input logic [11:0] a, input logic [7:0] wd, input logic r,
                               input logic w, input logic e, input logic [7:0] ac,
                               input logic [11:0] ee, input logic mr, input logic mw,
                               input logic [7:0] erd, input logic fb, input logic [3:0] rq);
    return '{a, wd, r, w, e, ac, ee, mr, mw, erd, fb, rq};
  endfunction

  localparam int NV = 45;
  localparam vec_t VECS [NV] = '{
    mkv(12'hFE9, 8'h34, 0,1,1, 8'h00, 12'hFE9, 0,0, 8'h00, 0, 4'd3),  // R3 low byte write
    mkv(12'hFEA, 8'hF2, 0,1,1, 8'h00, 12'hFEA, 0,0, 8'h00, 0, 4'd2),  // R2 high byte write
    mkv(12'hFEA, 8'h00, 1,0,1, 8'h00, 12'hFEA, 0,0, 8'h02, 0, 4'd2),  // R2 upper bits zero
    mkv(12'hFE9, 8'h00, 1,0,1, 8'h00, 12'hFE9, 0,0, 8'h34, 0, 4'd3),  // R3 low byte read
    mkv(12'hFEB, 8'h00, 1,0,1, 8'h00, 12'h234, 1,0, 8'h00, 0, 4'd5),  // R5 plain
    mkv(12'hFE9, 8'h00, 1,0,1, 8'h00, 12'hFE9, 0,0, 8'h34, 0, 4'd5),  // R5 unchanged
    mkv(12'hFEC, 8'h00, 1,0,0, 8'h00, 12'h234, 1,0, 8'h00, 0, 4'd9),  // R9 read phase
    mkv(12'hFE9, 8'h00, 1,0,0, 8'h00, 12'hFE9, 0,0, 8'h34, 0, 4'd9),  // R9 still held
    mkv(12'hFEC, 8'h00, 0,1,1, 8'h00, 12'h234, 0,1, 8'h00, 0, 4'd9),  // R9 write phase
    mkv(12'hFE9, 8'h00, 1,0,1, 8'h00, 12'hFE9, 0,0, 8'h35, 0, 4'd6),  // R6 step applied
    mkv(12'hFED, 8'h00, 1,0,1, 8'h00, 12'h235, 1,0, 8'h00, 0, 4'd10), // R10 strobe+end
    mkv(12'hFE9, 8'h00, 1,0,1, 8'h00, 12'hFE9, 0,0, 8'h34, 0, 4'd10), // R10 one step
    mkv(12'hFEE, 8'h00, 1,0,0, 8'h00, 12'h235, 1,0, 8'h00, 0, 4'd7),  // R7 first strobe
    mkv(12'hFEE, 8'h00, 0,1,1, 8'h00, 12'h235, 0,1, 8'h00, 0, 4'd7),  // R7 same address
    mkv(12'hFE9, 8'h00, 1,0,1, 8'h00, 12'hFE9, 0,0, 8'h35, 0, 4'd7),  // R7 stored once
    mkv(12'hFEF, 8'h00, 1,0,1, 8'hFE, 12'h233, 1,0, 8'h00, 0, 4'd8),  // R8 negative offset
    mkv(12'hFEF, 8'h00, 1,0,1, 8'h10, 12'h245, 1,0, 8'h00, 0, 4'd8),  // R8 positive offset
    mkv(12'hFE9, 8'h00, 1,0,1, 8'h00, 12'hFE9, 0,0, 8'h35, 0, 4'd8),  // R8 pointer kept
    mkv(12'h123, 8'h00, 1,0,1, 8'h00, 12'h123, 1,0, 8'h00, 0, 4'd4),  // R4 direct read
    mkv(12'h456, 8'h00, 0,1,1, 8'h00, 12'h456, 0,1, 8'h00, 0, 4'd4),  // R4 direct write
    mkv(12'hFE1, 8'hFF, 0,1,1, 8'h00, 12'hFE1, 0,0, 8'h00, 0, 4'd2),  // R2 channel 1 low
    mkv(12'hFE2, 8'h0F, 0,1,1, 8'h00, 12'hFE2, 0,0, 8'h00, 0, 4'd2),  // R2 channel 1 high
    mkv(12'hFE4, 8'h00, 1,0,1, 8'h00, 12'hFFF, 1,0, 8'h00, 0, 4'd6),  // R6 post-inc at top
    mkv(12'hFE1, 8'h00, 1,0,1, 8'h00, 12'hFE1, 0,0, 8'h00, 0, 4'd6),  // R6 wrapped low
    mkv(12'hFE2, 8'h00, 1,0,1, 8'h00, 12'hFE2, 0,0, 8'h00, 0, 4'd6),  // R6 wrapped high
    mkv(12'hFE5, 8'h00, 1,0,1, 8'h00, 12'h000, 1,0, 8'h00, 0, 4'd6),  // R6 post-dec at zero
    mkv(12'hFE2, 8'h00, 1,0,1, 8'h00, 12'hFE2, 0,0, 8'h0F, 0, 4'd6),  // R6 wrapped down
    mkv(12'hFE6, 8'h00, 1,0,1, 8'h00, 12'h000, 1,0, 8'h00, 0, 4'd7),  // R7 pre-inc wraps
    mkv(12'hFE1, 8'h00, 1,0,1, 8'h00, 12'hFE1, 0,0, 8'h00, 0, 4'd7),  // R7 wrapped store
    mkv(12'hFD9, 8'hE3, 0,1,1, 8'h00, 12'hFD9, 0,0, 8'h00, 0, 4'd2),  // R2 channel 2 low
    mkv(12'hFDA, 8'h0F, 0,1,1, 8'h00, 12'hFDA, 0,0, 8'h00, 0, 4'd2),  // R2 channel 2 high
    mkv(12'hFDB, 8'h00, 1,0,1, 8'h00, 12'hFE3, 0,0, 8'h00, 1, 4'd11), // R11 refused read
    mkv(12'hFDC, 8'h00, 0,1,1, 8'h00, 12'hFE3, 0,0, 8'h00, 1, 4'd11), // R11 refused write
    mkv(12'hFD9, 8'h00, 1,0,1, 8'h00, 12'hFD9, 0,0, 8'hE3, 0, 4'd11), // R11 no step, flag gone
    mkv(12'hFDF, 8'h00, 1,0,1, 8'h08, 12'hFEB, 0,0, 8'h00, 1, 4'd11), // R11 offset lands on view
    mkv(12'hFDF, 8'h00, 1,0,1, 8'h05, 12'hFE8, 1,0, 8'h00, 0, 4'd11), // R11 neighbour allowed
    mkv(12'hFDE, 8'h00, 1,0,1, 8'h00, 12'hFE4, 0,0, 8'h00, 1, 4'd11), // R11 refused pre-inc
    mkv(12'hFD9, 8'h00, 1,0,1, 8'h00, 12'hFD9, 0,0, 8'hE3, 0, 4'd11), // R11 pre-inc not stored
    mkv(12'hFD9, 8'h00, 0,1,1, 8'h00, 12'hFD9, 0,0, 8'h00, 0, 4'd12), // R12 set low
    mkv(12'hFDA, 8'h01, 0,1,1, 8'h00, 12'hFDA, 0,0, 8'h00, 0, 4'd12), // R12 set high
    mkv(12'hFDC, 8'h00, 1,0,0, 8'h00, 12'h100, 1,0, 8'h00, 0, 4'd12), // R12 step pending
    mkv(12'hFD9, 8'h50, 0,1,0, 8'h00, 12'hFD9, 0,0, 8'h00, 0, 4'd12), // R12 byte write cancels
    mkv(12'h000, 8'h00, 0,0,1, 8'h00, 12'h000, 0,0, 8'h00, 0, 4'd12), // R12 bare end
    mkv(12'hFD9, 8'h00, 1,0,1, 8'h00, 12'hFD9, 0,0, 8'h50, 0, 4'd12), // R12 written value kept
    mkv(12'hFDB, 8'h00, 1,0,1, 8'h00, 12'h150, 1,0, 8'h00, 0, 4'd12)  // R12 next access
  };

  task automatic drive(input vec_t v);
    @(negedge clk);
    reg_addr = v.addr; wr_data = v.wd; rd_stb = v.rd; wr_stb = v.wr;
    insn_end = v.en; acc = v.ac;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    reg_addr = '0; wr_data = '0; rd_stb = 0; wr_stb = 0; insn_end = 0; acc = '0;
    #1;
  endtask

  task automatic compare(input vec_t v, input string tag);
    logic [22:0] act, exp;
    act = {eff_addr, mem_rd, mem_wr, ptr_rdata, forbid};
    exp = {v.e_eff, v.e_mr, v.e_mw, v.e_rd, v.e_fb};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s R%0d eff/mr/mw/rdata/fb actual %h %b %b %h %b expected %h %b %b %h %b",
               tag, v.req, eff_addr, mem_rd, mem_wr, ptr_rdata, forbid,
               v.e_eff, v.e_mr, v.e_mw, v.e_rd, v.e_fb);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle outputs and zero pointers after reset
    idle();
    compare(mkv(12'h000, 0, 0,0,0, 0, 12'h000, 0,0, 8'h00, 0, 4'd1), "reset idle");
    drive(mkv(12'hFE9, 0, 1,0,1, 0, 0,0,0,0,0,0));
    compare(mkv(0, 0, 0,0,0, 0, 12'hFE9, 0,0, 8'h00, 0, 4'd1), "reset low R1");
    drive(mkv(12'hFDA, 0, 1,0,1, 0, 0,0,0,0,0,0));
    compare(mkv(0, 0, 0,0,0, 0, 12'hFDA, 0,0, 8'h00, 0, 4'd1), "reset high R1");
    drive(mkv(12'hFE3, 0, 1,0,1, 0, 0,0,0,0,0,0));
    compare(mkv(0, 0, 0,0,0, 0, 12'h000, 1,0, 8'h00, 0, 4'd1), "reset plain R1");

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      compare(VECS[i], "vector");
    end

    // R1: a reset in the middle of an instruction drops pointer and pending step
    drive(mkv(12'hFEC, 0, 1,0,0, 0, 0,0,0,0,0,0));
    compare(mkv(0, 0, 0,0,0, 0, 12'h235, 1,0, 8'h00, 0, 4'd1), "pending before reset");
    idle();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(mkv(12'hFE9, 0, 1,0,1, 0, 0,0,0,0,0,0));
    compare(mkv(0, 0, 0,0,0, 0, 12'hFE9, 0,0, 8'h00, 0, 4'd1), "after reset low R1");
    drive(mkv(12'hFEC, 0, 1,0,1, 0, 0,0,0,0,0,0));
    compare(mkv(0, 0, 0,0,0, 0, 12'h000, 1,0, 8'h00, 0, 4'd1), "after reset post R1");
    drive(mkv(12'hFE9, 0, 1,0,1, 0, 0,0,0,0,0,0));
    compare(mkv(0, 0, 0,0,0, 0, 12'hFE9, 0,0, 8'h01, 0, 4'd6), "single step R6");

    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule